// File: doc/BRIEF.md
# Start-up Offset Calibration Sequencer

This block sits in the digital path of a stereo sample stream, after the decimator. When its reset input is released, it runs one calibration cycle. During the cycle it keeps a busy flag high and averages the first frames of each channel into a per-channel offset. From then on it subtracts that offset from every sample of the same channel. The result is clamped to the signed 24-bit range. Output samples are held at zero until the data-valid flag rises, and data-valid rises a fixed number of frames after busy has dropped.

Frames are counted on `in_stb`, which pulses once per word-select period and carries one left and one right sample. The cycle length depends on two inputs, a speed select and a master/slave select, and both are captured when the cycle starts. The block does not switch the analog reference itself. It only reports the chosen source on `ref_pins_o` while busy is high.

Top module: `offset_cal_seq`

## Requirements
- R1: While `rst_n` is low, `busy_o`, `valid_o`, `ref_pins_o` and `out_stb` are 0, `out_left` and `out_right` are 0, and all stored offsets and counts are cleared.
- R2: `busy_o` rises in the second clock after `rst_n` goes high. It stays high until the strobe that completes frame B, where frames are numbered from 1. B is 8704 at normal speed (`speed_dbl`=0) and 17408 at double speed (`speed_dbl`=1).
- R3: `valid_o` rises together with the output of frame V and then stays high until reset. V is 8960 at normal speed and 17920 at double speed. `valid_o` is never high while `busy_o` is high.
- R4: With `slave_mode`=1, both B and V are one frame larger than with `slave_mode`=0.
- R5: Each channel's offset is the floor of the mean of frames 1 to 256 of that channel, treated as signed 24-bit values. The offset is fixed once it has been captured.
- R6: For every strobe from frame V on, `out_left` and `out_right` equal the input sample minus that channel's offset. The output is registered and appears, with `out_stb`=1, in the clock after the input strobe.
- R7: The difference saturates: a result above the positive limit gives 7FFFFF hex, and a result below the negative limit gives 800000 hex.
- R8: `ref_pins_o` equals `ref_sel` while `busy_o` is high and is 0 otherwise. 0 means the common-mode reference; 1 means the input pins.
- R9: For every strobe before frame V, `out_left` and `out_right` are 0.
- R10: `speed_dbl` and `slave_mode` are sampled in the first clock after reset release. Changing them later does not change B or V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; releasing it starts a calibration cycle |
| speed_dbl | input | 1 | 1 = double speed (longer cycle) |
| slave_mode | input | 1 | 1 = slave timing (one frame longer) |
| ref_sel | input | 1 | Reference select: 0 = common mode, 1 = input pins |
| in_stb | input | 1 | One pulse per frame; marks `in_left`/`in_right` as valid |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| busy_o | output | 1 | Calibration cycle in progress |
| valid_o | output | 1 | Output data valid |
| ref_pins_o | output | 1 | Reported measurement reference |
| out_stb | output | 1 | Output sample strobe |
| out_left | output | 24 | Corrected left sample |
| out_right | output | 24 | Corrected right sample |

## Verification
Two events share a single clock at frame V. The data-valid release and the first corrected output both appear there, and that first output must also be saturated. The bench drives full-scale samples on exactly frame V, with the opposite sign to each channel's offset. It expects one edge to produce `valid_o`, the clamped value and `out_stb` together. It also expects the output of frame V-1 to be zero. The mean uses floor rounding on both signs and is checked the same way, through the first valid frames.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
  localparam int SMP_W = 24;
  typedef logic signed [SMP_W-1:0] smp_t;

  localparam smp_t SMP_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam smp_t SMP_MIN = {1'b1, {(SMP_W-1){1'b0}}};

  // a - b, clamped to the signed sample range
  function automatic smp_t sat_sub(input smp_t a, input smp_t b);
    logic signed [SMP_W:0] d;
    d = {a[SMP_W-1], a} - {b[SMP_W-1], b};
    if (d[SMP_W] != d[SMP_W-1]) return d[SMP_W] ? SMP_MIN : SMP_MAX;
    return d[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/cal_frame_seq.sv
module cal_frame_seq #(
  parameter int BUSY_NS  = 8704,
  parameter int VALID_NS = 8960,
  parameter int AVG_LOG2 = 8,
  localparam int CW = $clog2(2*VALID_NS + 2) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_dbl,
  input  logic slave_mode,
  input  logic in_stb,
  output logic run_o,
  output logic busy_o,
  output logic valid_o,
  output logic stb_valid_o,
  output logic meas_en_o,
  output logic meas_last_o
);
  localparam logic [CW-1:0] MEAS_N = CW'(2**AVG_LOG2);

  function automatic logic [CW-1:0] frame_limit(input int base, input logic dbl, input logic slv);
    return (dbl ? CW'(2*base) : CW'(base)) + CW'(slv);
  endfunction

  logic run_q, dbl_q, slv_q;
  logic [CW-1:0] cnt_q, busy_lim, valid_lim;
  logic counted_stb;

  assign busy_lim    = frame_limit(BUSY_NS, dbl_q, slv_q);
  assign valid_lim   = frame_limit(VALID_NS, dbl_q, slv_q);
  assign counted_stb = run_q && in_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dbl_q <= 1'b0;
      slv_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
      dbl_q <= speed_dbl;
      slv_q <= slave_mode;
    end else if (in_stb && cnt_q < valid_lim) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_o       = run_q;
  assign busy_o      = run_q && (cnt_q < busy_lim);
  assign valid_o     = run_q && (cnt_q >= valid_lim);
  assign stb_valid_o = counted_stb && (cnt_q + 1'b1 >= valid_lim);
  assign meas_en_o   = counted_stb && (cnt_q < MEAS_N);
  assign meas_last_o = counted_stb && (cnt_q == MEAS_N - 1'b1);

  initial assert (2**AVG_LOG2 <= BUSY_NS && BUSY_NS < VALID_NS);

  p_busy_drop_on_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(in_stb));
  p_valid_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o);
  p_valid_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_o);
  p_modes_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(busy_lim) && $stable(valid_lim));
endmodule

// File: rtl/cal_offset_acc.sv
module cal_offset_acc #(
  parameter int AVG_LOG2 = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          meas_en,
  input  logic          meas_last,
  input  ocal_pkg::smp_t sample,
  output ocal_pkg::smp_t offset_o
);
  import ocal_pkg::*;
  localparam int AW = SMP_W + AVG_LOG2;

  logic signed [AW-1:0] acc_q, acc_sum;
  smp_t off_q;

  assign acc_sum = acc_q + {{AVG_LOG2{sample[SMP_W-1]}}, sample};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      off_q <= '0;
    end else if (meas_en) begin
      if (meas_last) begin
        off_q <= acc_sum[AW-1:AVG_LOG2];
        acc_q <= '0;
      end else begin
        acc_q <= acc_sum;
      end
    end
  end

  assign offset_o = off_q;

  p_meas_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_en |-> busy_i);
  p_offset_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> $stable(off_q));
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq #(
  parameter int BUSY_NS  = 8704,
  parameter int VALID_NS = 8960,
  parameter int AVG_LOG2 = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        speed_dbl,
  input  logic        slave_mode,
  input  logic        ref_sel,
  input  logic        in_stb,
  input  logic [23:0] in_left,
  input  logic [23:0] in_right,
  output logic        busy_o,
  output logic        valid_o,
  output logic        ref_pins_o,
  output logic        out_stb,
  output logic [23:0] out_left,
  output logic [23:0] out_right
);
  import ocal_pkg::*;
  localparam int NCH = 2;

  logic run, stb_valid, meas_en, meas_last;
  smp_t smp_in [NCH];
  smp_t offs   [NCH];
  smp_t res_q  [NCH];

  assign smp_in[0] = in_left;
  assign smp_in[1] = in_right;

  cal_frame_seq #(.BUSY_NS(BUSY_NS), .VALID_NS(VALID_NS), .AVG_LOG2(AVG_LOG2)) u_seq (
    .clk(clk), .rst_n(rst_n), .speed_dbl(speed_dbl), .slave_mode(slave_mode),
    .in_stb(in_stb), .run_o(run), .busy_o(busy_o), .valid_o(valid_o),
    .stb_valid_o(stb_valid), .meas_en_o(meas_en), .meas_last_o(meas_last)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cal_offset_acc #(.AVG_LOG2(AVG_LOG2)) u_acc (
      .clk(clk), .rst_n(rst_n), .busy_i(busy_o), .meas_en(meas_en),
      .meas_last(meas_last), .sample(smp_in[c]), .offset_o(offs[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                res_q[c] <= '0;
      else if (run && in_stb)    res_q[c] <= stb_valid ? sat_sub(smp_in[c], offs[c]) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_stb <= 1'b0;
    else        out_stb <= run && in_stb;
  end

  assign ref_pins_o = busy_o && ref_sel;
  assign out_left   = res_q[0];
  assign out_right  = res_q[1];

  p_zero_until_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb && !valid_o) |-> (out_left == '0 && out_right == '0));
  p_valid_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(!busy_o) && out_stb);
  p_ref_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !ref_pins_o);
endmodule

// File: tb/test_offset_cal_seq.sv
module test_offset_cal_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, speed_dbl = 1'b0, slave_mode = 1'b0, ref_sel = 1'b0, in_stb = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic busy_o, valid_o, ref_pins_o, out_stb;
  logic [23:0] out_left, out_right;

  offset_cal_seq i_offset_cal_seq (.*);

  typedef struct {
    int k; int v; logic [23:0] l, r; bit bz, vd, rp; string tag;
  } exp_t;
  exp_t q[$];
  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint clamp24(input longint v);
    if (v > 64'sd8388607)  return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  function automatic longint floor256(input longint s);
    if (s >= 0) return s / 256;
    return -((-s + 255) / 256);
  endfunction

  // monitor: compares every output strobe against the scoreboard
  always @(negedge clk) begin
    if (out_stb) begin
      if (q.size() == 0) begin
        check(1'b0, "R6", "unexpected out_stb", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(busy_o == e.bz, {"R2 ", e.tag}, $sformatf("busy frame %0d", e.k), busy_o, e.bz);
        check(valid_o == e.vd, {"R3 ", e.tag}, $sformatf("valid frame %0d", e.k), valid_o, e.vd);
        check(ref_pins_o == e.rp, "R8", $sformatf("ref frame %0d", e.k), ref_pins_o, e.rp);
        check(out_left == e.l && out_right == e.r,
              (e.k < e.v) ? "R9" : (e.k == e.v) ? "R7" : "R5 R6",
              $sformatf("data frame %0d", e.k), {out_left, out_right}, {e.l, e.r});
      end
    end
  end

  task automatic run_cal(input bit dbl, input bit slv, input bit sel, input bit flip,
                         input longint bl, input longint br, input string tag);
    int b, v;
    longint sum_l, sum_r, off_l, off_r;
    rst_n = 1'b0; in_stb = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy_o && !valid_o && !ref_pins_o && !out_stb && out_left == 0 && out_right == 0,
          "R1", "reset outputs", {busy_o, valid_o, ref_pins_o, out_stb}, 0);
    speed_dbl = dbl; slave_mode = slv; ref_sel = sel;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy_o && !valid_o, "R2", "busy after release", {busy_o, valid_o}, 2);
    check(ref_pins_o == sel, "R8", "ref during busy", ref_pins_o, sel);
    b = (dbl ? 17408 : 8704) + slv;
    v = (dbl ? 17920 : 8960) + slv;
    sum_l = 0; sum_r = 0; off_l = 0; off_r = 0;
    for (int k = 1; k <= v + 3; k++) begin
      longint sl, sr;
      exp_t e;
      if (k <= 256) begin
        sl = bl - (k % 2);
        sr = br + ((k % 3 == 0) ? 1 : 0);
        sum_l += sl; sum_r += sr;
        if (k == 256) begin off_l = floor256(sum_l); off_r = floor256(sum_r); end
      end else if (k == v) begin
        sl = (bl < 0) ? 64'sd8388607 : -64'sd8388608;
        sr = (br < 0) ? 64'sd8388607 : -64'sd8388608;
      end else if (k == v + 1) begin
        sl = (bl < 0) ? -64'sd8388608 : 64'sd8388607;
        sr = (br < 0) ? -64'sd8388608 : 64'sd8388607;
      end else begin
        sl = ((k * 1237) % 4001) - 2000;
        sr = 1500 - ((k * 733) % 3001);
      end
      e.k = k; e.v = v; e.tag = tag;
      e.bz = (k < b); e.vd = (k >= v); e.rp = e.bz && sel;
      e.l = e.vd ? 24'(clamp24(sl - off_l)) : 24'h0;
      e.r = e.vd ? 24'(clamp24(sr - off_r)) : 24'h0;
      q.push_back(e);
      in_left = 24'(sl); in_right = 24'(sr); in_stb = 1'b1;
      @(negedge clk) in_stb = 1'b0;
      if (flip && k == 5) begin speed_dbl = ~dbl; slave_mode = ~slv; end // R10
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);
    check(valid_o && !busy_o && !ref_pins_o, "R3", "final flags", {valid_o, busy_o, ref_pins_o}, 4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    run_cal(1'b0, 1'b0, 1'b1, 1'b0, -100, 200, "R2");
    run_cal(1'b0, 1'b1, 1'b0, 1'b1, 300, -50, "R4 R10");
    run_cal(1'b1, 1'b0, 1'b1, 1'b0, -100, 200, "R3");
    run_cal(1'b1, 1'b1, 1'b0, 1'b0, 300, -50, "R4");
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!valid_o && !busy_o && out_left == 0 && out_right == 0, "R1", "reset clears",
          {valid_o, busy_o}, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule